// File: doc/BRIEF.md
# I2C Serial Byte-Store Slave

This block is the bus-facing controller of a 2048-byte non-volatile store, split into eight banks of 256 bytes, all served by one device. It watches the two wires of an I2C bus through a clocked debounce. It recognises START, repeated START and STOP. It decodes a device byte whose upper nibble is the fixed type code and whose next three bits pick the bank. A following word byte sets the byte pointer inside that bank.

Writes go first into a 32-byte staging register. STOP launches a self-timed programming cycle that copies the staged bytes into the array, which is modelled as synchronous RAM. While that cycle runs, the device stays silent to its own address, so a master can poll for completion. Reads stream bytes MSB first from an auto-incrementing pointer. A write-protect input keeps the array from changing. The system clock runs many times faster than SCL, and every bus event is seen as an edge of the filtered lines.

Top module: `i2c_ee_slave`

## Requirements
- R1: A device byte is accepted only when its bits 7:4 are 1010; bits 3:1 are the bank and bit 0 is read (1) or write (0). Any other device byte gets no acknowledge, and the bytes that follow it cause no write cycle.
- R2: In a write, the byte after the device byte sets pointer bits 7:0, and the bank field sets bits 10:8. Each data byte is acknowledged and stored at the pointer, after which the pointer advances.
- R3: During a write, only pointer bits 4:0 advance, so data wraps inside the 32-byte page. A byte sent to an offset that was already filled in the same transfer replaces the earlier one.
- R4: The array is programmed only after STOP ends a write that carried at least one data byte. For TWR_CLKS clocks after that STOP, every device byte is left unacknowledged. After that, the device acknowledges again.
- R5: While wp_i is high, no array byte changes. If wp_i is high at the STOP, no write cycle starts, and the next device byte is acknowledged at once.
- R6: A read sends data MSB first, one byte per 9 SCL cycles. The pointer advances after every byte read, crossing bank boundaries and wrapping from 2047 to 0.
- R7: A read device byte replaces pointer bits 10:8 with its bank field and keeps bits 7:0. A read without a word byte therefore continues where the last access stopped.
- R8: After the master answers a read byte with NACK, the slave releases SDA, and a STOP then leaves the bus idle.
- R9: A level on SCL or SDA that lasts fewer than FILT_CLKS system clocks is ignored.
- R10: After reset, SDA is released, no write cycle is running, and the pointer is 0.
- R11: A START at any point, including inside a byte, restarts device-byte reception. A STOP returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect; high keeps the array unchanged |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
Launching the programming cycle at STOP and decoding the next device byte can land together: the bench polls with a fresh device byte immediately after the STOP that closes a page write. Each such poll must get a NACK until the timer runs out, and it must get an ACK at once when wp_i was high at that STOP. The data read back afterwards shows whether the staged bytes reached the array or were withheld. A second collision, a START arriving inside a data byte, is provoked with a repeated START after three bits. It is judged by the acknowledged read that follows and by the absence of a write cycle.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_SACK,
    ST_RDATA,
    ST_MACK
  } ee_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_ee_filt.sv
module i2c_ee_filt #(
  parameter int FILT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CLKS + 1);

  logic [1:0]    sync_q;
  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    stable_d = stable_q;
    cnt_d    = '0;
    if (sync_q[1] != stable_q) begin
      if (cnt_q == CW'(FILT_CLKS - 1)) stable_d = sync_q[1];
      else                             cnt_d    = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      stable_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      sync_q   <= {sync_q[0], din};
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
    end
  end

  assign dout = stable_q;

  generate
    if (FILT_CLKS >= 2) begin : g_chk
      // R9
      glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_q != $past(stable_q)) |->
          ($past(sync_q[1]) == stable_q && $past(sync_q[1], 2) == stable_q));
    end
  endgenerate
endmodule

// File: rtl/i2c_ee_ram.sv
module i2c_ee_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int PAGE_BYTES = 32,
  parameter int TWR_CLKS   = 1500,
  parameter int AW         = 8 + BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          wp_i,
  input  logic [7:0]    ram_q,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [7:0]    ram_wdata,
  output logic          sda_pull
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int IW = PW + 1;
  localparam int TW = $clog2(TWR_CLKS + 1);

  ee_state_e           state_q, state_d, ret_q, ret_d;
  logic [3:0]          bitcnt_q, bitcnt_d;
  logic [7:0]          sh_q, sh_d, tx_q, tx_d;
  logic                pull_q, pull_d, mnack_q, mnack_d;
  logic [AW-1:0]       ptr_q, ptr_d;
  logic [AW-PW-1:0]    base_q, base_d;
  logic                pend_q, pend_d, busy_q, busy_d;
  logic [PAGE_BYTES-1:0] valid_q, valid_d;
  logic [TW-1:0]       tmr_q, tmr_d;
  logic [IW-1:0]       eidx_q, eidx_d;
  logic                scl_q, sda_q;
  logic                pb_we;
  logic [7:0]          pbuf [PAGE_BYTES];

  logic scl_rise, scl_fall, start_det, stop_det, dev_match, eng_act;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign dev_match = (sh_q[7:4] == DEV_TYPE) && !busy_q;
  assign eng_act   = busy_q & ~eidx_q[IW-1];

  assign ram_raddr = ptr_q;
  assign ram_waddr = {base_q, eidx_q[PW-1:0]};
  assign ram_wdata = pbuf[eidx_q[PW-1:0]];
  assign ram_we    = eng_act & valid_q[eidx_q[PW-1:0]] & ~wp_i;
  assign sda_pull  = pull_q;

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    pull_d   = pull_q;
    mnack_d  = mnack_q;
    ptr_d    = ptr_q;
    base_d   = base_q;
    pend_d   = pend_q;
    valid_d  = valid_q;
    busy_d   = busy_q;
    tmr_d    = tmr_q;
    eidx_d   = eidx_q;
    pb_we    = 1'b0;

    if (busy_q) begin
      if (tmr_q == '0) busy_d = 1'b0;
      else             tmr_d  = tmr_q - TW'(1);
      if (eng_act) eidx_d = eidx_q + IW'(1);
    end

    if (start_det) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
      pull_d   = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      pull_d   = 1'b0;
      pend_d   = 1'b0;
      if (pend_q && !wp_i) begin
        busy_d = 1'b1;
        tmr_d  = TW'(TWR_CLKS - 1);
        eidx_d = '0;
      end
    end else begin
      case (state_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            sh_d     = {sh_q[6:0], sda_f};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            pull_d  = 1'b1;
            state_d = ST_SACK;
            case (state_q)
              ST_DEV: begin
                if (dev_match) begin
                  ptr_d[AW-1:8] = sh_q[BANK_W:1];
                  ret_d = sh_q[0] ? ST_RDATA : ST_ADDR;
                end else begin
                  pull_d  = 1'b0;
                  state_d = ST_IDLE;
                end
              end
              ST_ADDR: begin
                ptr_d[7:0] = sh_q;
                base_d     = {ptr_q[AW-1:8], sh_q[7:PW]};
                valid_d    = '0;
                ret_d      = ST_WDATA;
              end
              default: begin
                pb_we   = 1'b1;
                valid_d[ptr_q[PW-1:0]] = 1'b1;
                pend_d  = 1'b1;
                ptr_d   = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
                ret_d   = ST_WDATA;
              end
            endcase
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            state_d  = ret_q;
            pull_d   = 1'b0;
            if (ret_q == ST_RDATA) begin
              tx_d   = ram_q;
              pull_d = ~ram_q[7];
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_q + AW'(1);
              state_d = ST_MACK;
            end else begin
              pull_d = ~tx_q[3'd7 - bitcnt_q[2:0]];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mnack_d = sda_f;
          end else if (scl_fall) begin
            if (!mnack_q) begin
              tx_d     = ram_q;
              pull_d   = ~ram_q[7];
              bitcnt_d = '0;
              state_d  = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ret_q    <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      pull_q   <= 1'b0;
      mnack_q  <= 1'b0;
      ptr_q    <= '0;
      base_q   <= '0;
      pend_q   <= 1'b0;
      valid_q  <= '0;
      busy_q   <= 1'b0;
      tmr_q    <= '0;
      eidx_q   <= '0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      ret_q    <= ret_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      pull_q   <= pull_d;
      mnack_q  <= mnack_d;
      ptr_q    <= ptr_d;
      base_q   <= base_d;
      pend_q   <= pend_d;
      valid_q  <= valid_d;
      busy_q   <= busy_d;
      tmr_q    <= tmr_d;
      eidx_q   <= eidx_d;
      scl_q    <= scl_f;
      sda_q    <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[ptr_q[PW-1:0]] <= sh_q;
  end

  // R4
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pull_q);

  // R4
  prog_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stop_det));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !pull_q));

  // R11
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_DEV && bitcnt_q == 4'd0));
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter int BANKS      = 8,
  parameter int PAGE_BYTES = 32,
  parameter int FILT_CLKS  = 4,
  parameter int TWR_CLKS   = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);
  localparam int MEM_BYTES = BANKS * 256;
  localparam int BANK_W    = $clog2(BANKS);
  localparam int AW        = $clog2(MEM_BYTES);

  logic [1:0]    rst_q;
  logic          rst_sync_n;
  logic [1:0]    bus_raw, bus_flt;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign bus_raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flt
      i2c_ee_filt #(.FILT_CLKS(FILT_CLKS)) u_flt (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .din  (bus_raw[g]),
        .dout (bus_flt[g])
      );
    end
  endgenerate

  i2c_ee_ctrl #(
    .BANK_W    (BANK_W),
    .PAGE_BYTES(PAGE_BYTES),
    .TWR_CLKS  (TWR_CLKS),
    .AW        (AW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (bus_flt[1]),
    .sda_f    (bus_flt[0]),
    .wp_i     (wp_i),
    .ram_q    (ram_q),
    .ram_raddr(ram_raddr),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata),
    .sda_pull (sda_pull_o)
  );

  i2c_ee_ram #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |-> !wp_i);
endmodule

// File: tb/i2c_ee_slave_bench.sv
module i2c_ee_slave_bench;
  localparam int Q    = 16;
  localparam int FILT = 4;
  localparam int TWR  = 1500;

  logic clk, rst_n, m_scl, m_sda, wp, sda_pull, sda_line;
  int   n_chk, n_fail;
  logic [7:0] model [2048];
  bit         known [2048];
  logic [7:0] wbuf  [40];
  bit         done;

  assign sda_line = m_sda & ~sda_pull;

  i2c_ee_slave #(.FILT_CLKS(FILT), .TWR_CLKS(TWR)) u_i2c_ee_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .wp_i(wp), .sda_pull_o(sda_pull)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask

  task automatic put_bit(input bit b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      repeat (5) @(negedge clk); m_scl = 1'b1;
      repeat (FILT - 1) @(negedge clk); m_scl = 1'b0;
      repeat (Q - 5 - (FILT - 1)) @(negedge clk);
      m_scl = 1'b1; repeat (5) @(negedge clk);
      if (b) begin
        m_sda = 1'b0; repeat (FILT - 1) @(negedge clk); m_sda = 1'b1;
        repeat (2 * Q - 5 - (FILT - 1)) @(negedge clk);
      end else repeat (2 * Q - 5) @(negedge clk);
      m_scl = 1'b0; qwait();
    end else begin
      qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
    end
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    b = sda_line; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit more);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!more, 1'b0);
  endtask

  function automatic logic [7:0] dev_byte(input int a, input bit rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  // expected result of a page write: only offset bits 4:0 advance
  function automatic void model_page(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      int t = (a & 32'h7E0) | ((a + i) & 32'h1F);
      model[t] = wbuf[i];
      known[t] = 1'b1;
    end
  endfunction

  task automatic do_write(input int a, input int n, input bit glitch);
    bit ack;
    bus_start();
    send_byte(dev_byte(a, 1'b0), 1'b0, ack); check(ack, "R1", ack, 1);
    send_byte(a[7:0], 1'b0, ack);           check(ack, "R2", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], glitch, ack);
      check(ack, glitch ? "R9" : "R2", ack, 1);
    end
    bus_stop();
    if (!wp) model_page(a, n);
  endtask

  task automatic poll_ready(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_byte(8'hA0, 1'b0, ack);
      bus_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic read_seq(input int a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(a, 1'b0), 1'b0, ack); check(ack, "R2", ack, 1);
    send_byte(a[7:0], 1'b0, ack);           check(ack, "R2", ack, 1);
    bus_start();
    send_byte(dev_byte(a, 1'b1), 1'b0, ack); check(ack, "R11", ack, 1);
    for (int i = 0; i < n; i++) begin
      int t = (a + i) % 2048;
      recv_byte(d, i != n - 1);
      if (known[t]) check(d == model[t], req, d, model[t]);
    end
    bus_stop();
  endtask

  task automatic cur_read(input int bank, input int exp_a, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, 3'(bank), 1'b1}, 1'b0, ack); check(ack, req, ack, 1);
    recv_byte(d, 1'b0);
    check(d == model[exp_a], req, d, model[exp_a]);
    check(sda_pull == 1'b0, "R8", sda_pull, 0);
    bus_stop();
    check(sda_pull == 1'b0, "R8", sda_pull, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nacks, a, n, seed;
    bit ack;
    logic [7:0] d;
    done = 1'b0; n_chk = 0; n_fail = 0;
    for (int i = 0; i < 2048; i++) begin known[i] = 1'b0; model[i] = 8'h00; end
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk); rst_n = 1'b1; repeat (10) @(negedge clk);
    // R10 released line after reset
    check(sda_pull == 1'b0, "R10", sda_pull, 0);

    // R1 foreign type code: no ack, trailing bytes cause no write cycle
    bus_start();
    send_byte(8'hB0, 1'b0, ack); check(!ack, "R1", ack, 0);
    send_byte(8'h00, 1'b0, ack); send_byte(8'h55, 1'b0, ack);
    bus_stop();
    poll_ready(nacks); check(nacks == 0, "R1", nacks, 0);

    // R2 R4 page write, polling during the write cycle
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i * 7);
    do_write(32'h210, 4, 1'b0);
    poll_ready(nacks); check(nacks >= 1, "R4", nacks, 1);
    check(nacks <= 3, "R4", nacks, 3);
    read_seq(32'h210, 4, "R2");

    // R3 offset wrap inside the page
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write(32'h33E, 5, 1'b0);
    poll_ready(nacks);
    read_seq(32'h320, 3, "R3");
    read_seq(32'h33E, 2, "R3");

    // R3 33 bytes: the last one replaces offset 0
    for (int i = 0; i < 33; i++) wbuf[i] = 8'(i * 5 + 3);
    do_write(32'h400, 33, 1'b0);
    poll_ready(nacks);
    read_seq(32'h400, 2, "R3");
    read_seq(32'h41F, 1, "R3");

    // R5 protected write: no cycle, array unchanged
    wp = 1'b1;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hEE;
    do_write(32'h210, 3, 1'b0);
    poll_ready(nacks); check(nacks == 0, "R5", nacks, 0);
    wp = 1'b0;
    read_seq(32'h210, 3, "R5");

    // R6 read crossing bank boundaries and the top of the array
    wbuf[0] = 8'h7A; wbuf[1] = 8'h7B; do_write(32'h7FE, 2, 1'b0); poll_ready(nacks);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; do_write(32'h000, 2, 1'b0); poll_ready(nacks);
    wbuf[0] = 8'h9F; do_write(32'h1FF, 1, 1'b0); poll_ready(nacks);
    wbuf[0] = 8'hA5; do_write(32'h200, 1, 1'b0); poll_ready(nacks);
    read_seq(32'h7FE, 4, "R6");
    read_seq(32'h1FF, 2, "R6");

    // R7 address-only write in bank 2, then read naming bank 3
    bus_start();
    send_byte(8'hA4, 1'b0, ack); send_byte(8'h20, 1'b0, ack);
    bus_stop();
    cur_read(3, 32'h320, "R7");
    cur_read(3, 32'h321, "R6");

    // R10 reset returns the pointer to 0
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (10) @(negedge clk);
    check(sda_pull == 1'b0, "R10", sda_pull, 0);
    cur_read(0, 32'h000, "R10");

    // R9 short pulses on both lines during data bits
    wbuf[0] = 8'hB6; wbuf[1] = 8'h49;
    do_write(32'h500, 2, 1'b1);
    poll_ready(nacks);
    read_seq(32'h500, 2, "R9");

    // R11 repeated START inside a data byte
    bus_start();
    send_byte(8'hAA, 1'b0, ack); send_byte(8'h00, 1'b0, ack);
    put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0);
    bus_start();
    send_byte(8'hAB, 1'b0, ack); check(ack, "R11", ack, 1);
    recv_byte(d, 1'b0);
    check(d == model[32'h500], "R11", d, model[32'h500]);
    bus_stop();
    poll_ready(nacks); check(nacks == 0, "R11", nacks, 0);

    // random page writes with read back
    seed = $urandom(32'd715);
    for (int r = 0; r < 3; r++) begin
      a = $urandom % 2048;
      n = 1 + ($urandom % 5);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, 1'b0);
      poll_ready(nacks); check(nacks >= 1, "R4", nacks, 1);
      read_seq(a, (n < 32 - (a % 32)) ? n : 32 - (a % 32), "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule